// File: doc/BRIEF.md
# Paced DAC Code Register Interface

This block is the digital front end of a 12-bit waveform DAC. Software reaches it over a plain memory-mapped port (address, write data, write enable, combinational read data). It holds a configuration word and a code word, plus a small calibration bank: a lock word, one shared gain trim and four offset trims. The block runs on the analog clock, and a programmable divider sets how often a new code reaches the converter.

At each update strobe the block takes the stored code and limits it to the legal window around midscale. It then applies the gain trim and adds the offset trim picked by the power-mode input and the attenuator bit. The result is saturated to 12 bits and driven out, with a one-cycle update pulse. A code written between strobes waits for the next strobe. The calibration bank accepts writes only while the lock word holds the unlock key.

Top module: `paced_dac_ctrl`

## Requirements
- R1: After reset the registers read as follows: configuration 0x0000001E, code 0x00000800, lock 0xDE87A5A0, gain 0x00000800 and all four offsets 0. `dac_code` is 0x800, `dac_upd` is 0, and `amp_lo_gain` and `atten_on` are 0.
- R2: The register map is: configuration at 0x2010, with the attenuator enable in bit 0, the update period in bits [8:1] and the amplifier low-gain select in bit 12; code at 0x2048 in bits [11:0]; lock at 0x2100 (32 bits); gain at 0x2104 in [11:0]; offsets at 0x2108, 0x210C, 0x2110 and 0x2114 in [11:0]. Reserved bits and unmapped addresses read 0. `atten_on` and `amp_lo_gain` follow bits 0 and 12.
- R3: `dac_upd` pulses once every N analog clocks, where N is the period field. A period of 0 or 1 gives a pulse on every clock. With the reset period of 15, the first pulse comes 15 clocks after reset is released.
- R4: `dac_code` changes only together with a `dac_upd` pulse. A code written mid-period is presented at a later pulse, never between pulses.
- R5: Before correction the code is clamped: values below 0x200 become 0x200 and values above 0xE00 become 0xE00. The code register still reads back the value as written.
- R6: The offset trim is chosen from {mode_hs, attenuator bit}: 00 uses 0x2108, 01 uses 0x210C, 10 uses 0x2110 and 11 uses 0x2114. `mode_hs` is sampled at the strobe. Offsets are 12-bit two's complement.
- R7: The output is floor((clamped − 0x800) × gain / 0x800) + 0x800 + offset.
- R8: A corrected value below 0 is output as 0x000, and one above 0xFFF is output as 0xFFF.
- R9: Writes to the gain and offset registers are ignored unless the lock register holds 0x600DCA1B. The lock register itself is always writable, and every register is always readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Analog clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, one write per clock |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mode_hs | input | 1 | 1 = high speed mode, 0 = low power mode |
| amp_lo_gain | output | 1 | Excitation amplifier gain select (1 = 0.25, 0 = 2) |
| atten_on | output | 1 | Output attenuator enable |
| dac_code | output | 12 | Corrected code to the converter |
| dac_upd | output | 1 | One-cycle update strobe |

## Verification
A register write lands at the clock edge that samples `bus_we`, and the new value can be read back at the next falling edge. The internal strobe and the output registers are one edge apart, so `dac_upd` and its `dac_code` appear one clock after the divider wraps. The first pulse is therefore seen at the 15th falling edge after reset is released, and later pulses are exactly N falling edges apart. A write can share an edge with a strobe that still uses the old inputs, so after any change the bench skips the next pulse and checks the one after it.

// File: rtl/paced_dac_ctrl.sv
module paced_dac_ctrl #(
  parameter int ADDR_W = 16,
  parameter int CODE_W = 12,
  parameter logic [31:0] UNLOCK_KEY = 32'h600D_CA1B,
  parameter logic [ADDR_W-1:0] A_CFG = 16'h2010,
  parameter logic [ADDR_W-1:0] A_CODE = 16'h2048,
  parameter logic [ADDR_W-1:0] A_LOCK = 16'h2100,
  parameter logic [ADDR_W-1:0] A_GAIN = 16'h2104,
  parameter logic [ADDR_W-1:0] A_OFF0 = 16'h2108
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic              mode_hs,
  output logic              amp_lo_gain,
  output logic              atten_on,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_upd
);
  localparam int RATE_W = 8;
  localparam int MID = 1 << (CODE_W - 1);
  localparam int LO = MID >> 2;
  localparam int HI = 2 * MID - LO;
  localparam int DW = CODE_W + 1;
  localparam int PW = 2 * DW;
  localparam int SW = CODE_W + 6;

  logic [RATE_W-1:0] cfg_rate, cnt, period_m1;
  logic              cfg_amp, cfg_att;
  logic [CODE_W-1:0] code_q, gain_q, off_sel, clamped, corr;
  logic [CODE_W-1:0] off_q [4];
  logic [31:0]       lock_q;
  logic              cal_open, tick;
  logic signed [DW-1:0] delta;
  logic signed [PW-1:0] prod;
  logic signed [SW-1:0] scaled, offs, total;

  assign amp_lo_gain = cfg_amp;
  assign atten_on    = cfg_att;
  assign cal_open    = (lock_q == UNLOCK_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rate <= RATE_W'(15);
      cfg_amp  <= 1'b0;
      cfg_att  <= 1'b0;
      code_q   <= CODE_W'(MID);
      lock_q   <= 32'hDE87_A5A0;
      gain_q   <= CODE_W'(MID);
      for (int i = 0; i < 4; i++) off_q[i] <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_CFG) begin
        cfg_att  <= bus_wdata[0];
        cfg_rate <= bus_wdata[8:1];
        cfg_amp  <= bus_wdata[12];
      end
      if (bus_addr == A_CODE) code_q <= bus_wdata[CODE_W-1:0];
      if (bus_addr == A_LOCK) lock_q <= bus_wdata;
      if (cal_open && bus_addr == A_GAIN) gain_q <= bus_wdata[CODE_W-1:0];
      for (int i = 0; i < 4; i++)
        if (cal_open && bus_addr == A_OFF0 + ADDR_W'(4 * i))
          off_q[i] <= bus_wdata[CODE_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG:   bus_rdata = {19'b0, cfg_amp, 3'b0, cfg_rate, cfg_att};
      A_CODE:  bus_rdata = 32'(code_q);
      A_LOCK:  bus_rdata = lock_q;
      A_GAIN:  bus_rdata = 32'(gain_q);
      default: bus_rdata = '0;
    endcase
    for (int i = 0; i < 4; i++)
      if (bus_addr == A_OFF0 + ADDR_W'(4 * i)) bus_rdata = 32'(off_q[i]);
  end

  assign period_m1 = (cfg_rate < RATE_W'(2)) ? '0 : cfg_rate - RATE_W'(1);
  assign tick      = (cnt >= period_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= tick ? '0 : cnt + RATE_W'(1);
  end

  assign clamped = (code_q < CODE_W'(LO)) ? CODE_W'(LO) :
                   (code_q > CODE_W'(HI)) ? CODE_W'(HI) : code_q;
  assign off_sel = off_q[{mode_hs, cfg_att}];
  assign delta   = $signed({1'b0, clamped}) - $signed(DW'(MID));
  assign prod    = delta * $signed({1'b0, gain_q});
  assign scaled  = SW'(prod >>> (CODE_W - 1));
  assign offs    = SW'($signed(off_sel));
  assign total   = scaled + offs + SW'(MID);
  assign corr    = (total < 0) ? '0 :
                   (total > SW'((1 << CODE_W) - 1)) ? '1 : total[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code <= CODE_W'(MID);
      dac_upd  <= 1'b0;
    end else begin
      dac_upd <= tick;
      if (tick) dac_code <= corr;
    end
  end
endmodule

// File: rtl/paced_dac_ctrl_chk.sv
module paced_dac_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int CODE_W = 12,
  parameter logic [31:0] UNLOCK_KEY = 32'h600D_CA1B,
  parameter logic [ADDR_W-1:0] A_GAIN = 16'h2104
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_upd,
  input logic [7:0]        rate,
  input logic              tick,
  input logic [CODE_W-1:0] gain_q,
  input logic [CODE_W-1:0] off_sel,
  input logic [31:0]       lock_q
);
  localparam int MID = 1 << (CODE_W - 1);

  assert_reset_out_R1: assert property (@(posedge clk)
    !rst_n |=> (dac_code == CODE_W'(MID) && !dac_upd));

  assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_upd && rate >= 8'd2) |=> !dac_upd);

  assert_code_only_on_upd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_upd |-> $stable(dac_code));

  assert_clamp_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gain_q == CODE_W'(MID) && off_sel == '0) |=>
      (dac_code >= CODE_W'(MID >> 2) && dac_code <= CODE_W'(2 * MID - (MID >> 2))));

  assert_locked_gain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_GAIN && lock_q != UNLOCK_KEY) |=> $stable(gain_q));
endmodule

bind paced_dac_ctrl paced_dac_ctrl_chk #(
  .ADDR_W(ADDR_W), .CODE_W(CODE_W), .UNLOCK_KEY(UNLOCK_KEY), .A_GAIN(A_GAIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .dac_code(dac_code), .dac_upd(dac_upd), .rate(cfg_rate), .tick(tick),
  .gain_q(gain_q), .off_sel(off_sel), .lock_q(lock_q)
);

// File: tb/tb_paced_dac_ctrl.sv
module tb_paced_dac_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, mode_hs = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic amp_lo_gain, atten_on, dac_upd;
  logic [11:0] dac_code;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  localparam logic [15:0] A_CFG = 16'h2010, A_CODE = 16'h2048, A_LOCK = 16'h2100,
                          A_GAIN = 16'h2104, A_OFF0 = 16'h2108;
  localparam logic [31:0] KEY = 32'h600D_CA1B;

  paced_dac_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .mode_hs(mode_hs), .amp_lo_gain(amp_lo_gain),
    .atten_on(atten_on), .dac_code(dac_code), .dac_upd(dac_upd));

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_upd();
    int n = 0;
    do begin @(negedge clk); n++; end while (!dac_upd && n < 1000);
    if (n >= 1000) chk("R3 strobe timeout", 32'(dac_upd), 32'd1);
  endtask

  task automatic settle(output logic [11:0] c);
    wait_upd(); wait_upd();
    c = dac_code;
  endtask

  function automatic int model(int code, int gain, int off);
    int c, p, s, r;
    c = code;
    if (c < 512) c = 512;
    if (c > 3584) c = 3584;
    p = (c - 2048) * gain;
    s = p >>> 11;
    if (off >= 2048) off -= 4096;
    r = s + 2048 + off;
    if (r < 0) r = 0;
    if (r > 4095) r = 4095;
    return r;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    chk("R1 dac_code", 32'(dac_code), 32'h800);
    chk("R1 dac_upd", 32'(dac_upd), 32'd0);
    chk("R1 gain/atten pins", 32'({amp_lo_gain, atten_on}), 32'd0);
    rd(A_CFG, d);  chk("R1 cfg", d, 32'h1E);
    rd(A_CODE, d); chk("R1 code", d, 32'h800);
    rd(A_LOCK, d); chk("R1 lock", d, 32'hDE87A5A0);
    rd(A_GAIN, d); chk("R1 gain", d, 32'h800);
    for (int i = 0; i < 4; i++) begin
      rd(A_OFF0 + 16'(4 * i), d); chk("R1 offset", d, 32'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!dac_upd && n < 100);
      chk("R3 first pulse after reset", 32'(n), 32'd15);
      chk("R1 first output", 32'(dac_code), 32'h800);
    end
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, d); chk("R2 cfg reserved bits", d, 32'h11FF);
    chk("R2 pins follow cfg", 32'({amp_lo_gain, atten_on}), 32'd3);
    wr(A_CODE, 32'hFFFF_FFFF);
    rd(A_CODE, d); chk("R2 code width", d, 32'hFFF);
    rd(16'h2000, d); chk("R2 unmapped", d, 32'd0);
    wr(A_CFG, 32'h8);
    rd(A_CFG, d); chk("R2 cfg rate 4", d, 32'h8);
    chk("R2 pins cleared", 32'({amp_lo_gain, atten_on}), 32'd0);
  endtask

  task automatic measure(int rate, int exp);
    int n = 0;
    wr(A_CFG, 32'(rate << 1));
    wait_upd(); wait_upd();
    do begin @(negedge clk); n++; end while (!dac_upd && n < 1000);
    chk($sformatf("R3 period rate=%0d", rate), 32'(n), 32'(exp));
  endtask

  task automatic t_pace();
    measure(5, 5); measure(2, 2); measure(1, 1); measure(0, 1); measure(4, 4);
  endtask

  task automatic t_hold();
    logic [11:0] c;
    bit stable_ok = 1;
    wr(A_CODE, 32'h800);
    wr(A_CFG, 32'(20 << 1));
    settle(c);
    wr(A_CODE, 32'hA00);
    while (!dac_upd) begin
      if (dac_code !== 12'h800) stable_ok = 0;
      @(negedge clk);
    end
    chk("R4 held between pulses", 32'(stable_ok), 32'd1);
    chk("R4 taken at pulse", 32'(dac_code), 32'hA00);
    wr(A_CFG, 32'h8);
  endtask

  task automatic clamp_one(logic [11:0] code, logic [11:0] exp);
    logic [11:0] c;
    logic [31:0] d;
    wr(A_CODE, 32'(code));
    settle(c);
    chk($sformatf("R5 clamp %h", code), 32'(c), 32'(exp));
    rd(A_CODE, d); chk("R5 readback unclamped", d, 32'(code));
  endtask

  task automatic t_clamp();
    clamp_one(12'h000, 12'h200); clamp_one(12'h1FF, 12'h200);
    clamp_one(12'h200, 12'h200); clamp_one(12'hE00, 12'hE00);
    clamp_one(12'hE01, 12'hE00); clamp_one(12'hFFF, 12'hE00);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    logic [11:0] c;
    wr(A_GAIN, 32'h400);
    rd(A_GAIN, d); chk("R9 locked gain write ignored", d, 32'h800);
    wr(A_OFF0, 32'h10);
    rd(A_OFF0, d); chk("R9 locked offset write ignored", d, 32'd0);
    wr(A_CODE, 32'hA00);
    settle(c); chk("R9 output untouched while locked", 32'(c), 32'hA00);
    wr(A_LOCK, KEY);
    rd(A_LOCK, d); chk("R9 lock readable", d, KEY);
    wr(A_GAIN, 32'h400);
    rd(A_GAIN, d); chk("R9 unlocked gain write", d, 32'h400);
    wr(A_LOCK, 32'h0);
    wr(A_GAIN, 32'h123);
    rd(A_GAIN, d); chk("R9 relocked gain write ignored", d, 32'h400);
    wr(A_LOCK, KEY);
  endtask

  task automatic t_gain();
    logic [11:0] c;
    int codes[4] = '{12'hA00, 12'h600, 12'h801, 12'h7FF};
    wr(A_GAIN, 32'h400);
    foreach (codes[i]) begin
      wr(A_CODE, 32'(codes[i]));
      settle(c);
      chk($sformatf("R7 gain 0x400 code %h", codes[i]), 32'(c), 32'(model(codes[i], 'h400, 0)));
    end
    wr(A_GAIN, 32'h800);
  endtask

  task automatic t_offset();
    logic [11:0] c;
    int offs[4] = '{'h010, 'h020, 'hFF0, 'h030};
    foreach (offs[i]) wr(A_OFF0 + 16'(4 * i), 32'(offs[i]));
    wr(A_CODE, 32'h800);
    for (int sel = 0; sel < 4; sel++) begin
      mode_hs = sel[1];
      wr(A_CFG, 32'h8 | 32'(sel[0]));
      settle(c);
      chk($sformatf("R6 offset select %0d", sel), 32'(c), 32'(model('h800, 'h800, offs[sel])));
    end
    mode_hs = 1'b0;
    wr(A_CFG, 32'h8);
    foreach (offs[i]) wr(A_OFF0 + 16'(4 * i), 32'd0);
  endtask

  task automatic t_sat();
    logic [11:0] c;
    wr(A_GAIN, 32'hFFF);
    wr(A_CODE, 32'hE00); settle(c); chk("R8 high saturation by gain", 32'(c), 32'hFFF);
    wr(A_CODE, 32'h200); settle(c); chk("R8 low saturation by gain", 32'(c), 32'h000);
    wr(A_GAIN, 32'h800);
    wr(A_OFF0, 32'h7FF);
    wr(A_CODE, 32'hE00); settle(c); chk("R8 high saturation by offset", 32'(c), 32'hFFF);
    wr(A_OFF0, 32'h800);
    wr(A_CODE, 32'h200); settle(c); chk("R8 low saturation by offset", 32'(c), 32'h000);
    wr(A_OFF0, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_map();
    t_pace();
    t_hold();
    t_clamp();
    t_lock();
    t_gain();
    t_offset();
    t_sat();
    finish_run();
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end
endmodule